// File: doc/BRIEF.md
# Strap-Addressed I2C Control/Status Target

This block is a bus target on a two-wire serial bus. It owns a single 8-bit control byte and reports a single 8-bit status byte. It samples the serial clock and data lines through a short synchroniser, then recognises bus start and stop conditions. It takes in the address byte and answers only its own address. The upper address bits are fixed by a parameter. The lowest three bits come from strap inputs, so up to eight copies of the same device can share one bus.

A master write to the matched address loads the control byte. If the master sends more bytes in the same transfer, each one replaces the byte before it. A master read shifts out the status byte, which comes from outside the block, highest bit first. The status is sampled again for each byte the master acknowledges. The block only ever pulls the data line low, through an open-drain enable output. It never stretches the clock.

Top module: `strap_i2c_target`

## Requirements
- R1: The target acknowledges by driving SDA low during the ninth clock of an address byte. It does so only when the byte equals 40h + 2*strap_i, with bit 0 as the read/write flag (0 = write, 1 = read).
- R2: For any other address byte, the target never drives SDA for the rest of the transfer. It ignores written bytes and returns all ones on a read.
- R3: On a matched write, each data byte loads ctrl_o and is acknowledged. When several bytes arrive in one transfer, the last one is what remains.
- R4: On a matched read, the target drives status_i onto SDA highest bit first. The value used is the one present when the previous acknowledge clock ended.
- R5: While the master acknowledges, the read continues with a freshly sampled status byte. After a master not-acknowledge, the target releases SDA and stays silent.
- R6: During and straight after reset, ctrl_o is 00h and sda_oe_o is 0.
- R7: A stop condition at any point abandons the transfer without touching ctrl_o. A start condition at any point, including a repeated start, begins a new address phase.
- R8: The target never drives SDA while SCL is high during a bit the master is sending (address bits or write data bits).
- R9: ctrl_o changes only when a complete write data byte has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Address strap pins, low address bits |
| status_i | input | 8 | Status byte returned on reads |
| ctrl_o | output | 8 | Control byte written by the master |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench checks every strap value against its own address. If the strap bits were mapped to the wrong positions, one of those addresses would go unacknowledged. A neighbouring address is sent to a target whose strap does not match. A target that matched on too few bits would then acknowledge it and could overwrite the control byte. Writes are cut off by a stop halfway through a byte, and a repeated start is sent straight after an address acknowledge. A design that failed to return to idle would load a partial byte, or would treat the new address as data. Multi-byte reads change status_i between bytes. A target that sampled status at the wrong moment, or kept driving after a not-acknowledge, would return stale bits or hold SDA low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_evt = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_evt  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              sda_oe_o,
    output tgt_state_e        state_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] ctrl;
        logic              oe;
        logic              rw;
        logic              nack;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                d.oe = 1'b0;
            end
            ST_ADDR: begin
                if (scl_rise) begin
                    d.shreg = {q.shreg[DATA_W-2:0], sda_lvl};
                    d.cnt   = q.cnt + 1'b1;
                end else if (scl_fall && q.cnt == CNT_FULL) begin
                    d.cnt = '0;
                    if (q.shreg[DATA_W-1:1] == own_addr) begin
                        d.state = ST_ADDR_ACK;
                        d.oe    = 1'b1;
                        d.rw    = q.shreg[0];
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.state = ST_RD;
                        d.shreg = status_i;
                        d.oe    = ~status_i[DATA_W-1];
                    end else begin
                        d.state = ST_WR;
                        d.oe    = 1'b0;
                    end
                end
            end
            ST_WR: begin
                if (scl_rise) begin
                    d.shreg = {q.shreg[DATA_W-2:0], sda_lvl};
                    d.cnt   = q.cnt + 1'b1;
                end else if (scl_fall && q.cnt == CNT_FULL) begin
                    d.ctrl  = q.shreg;
                    d.oe    = 1'b1;
                    d.cnt   = '0;
                    d.state = ST_WR_ACK;
                end
            end
            ST_WR_ACK: begin
                if (scl_fall) begin
                    d.oe    = 1'b0;
                    d.state = ST_WR;
                end
            end
            ST_RD: begin
                if (scl_fall) begin
                    if (q.cnt == CNT_LAST) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.state = ST_RD_ACK;
                    end else begin
                        d.cnt   = q.cnt + 1'b1;
                        d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                        d.oe    = ~q.shreg[DATA_W-2];
                    end
                end
            end
            ST_RD_ACK: begin
                if (scl_rise) begin
                    d.nack = sda_lvl;
                end else if (scl_fall) begin
                    if (q.nack) begin
                        d.state = ST_IDLE;
                        d.oe    = 1'b0;
                    end else begin
                        d.state = ST_RD;
                        d.shreg = status_i;
                        d.oe    = ~status_i[DATA_W-1];
                        d.cnt   = '0;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.oe    = 1'b0;
            end
        endcase

        if (start_evt) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (stop_evt) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.shreg <= '0;
            q.ctrl  <= '0;
            q.oe    <= 1'b0;
            q.rw    <= 1'b0;
            q.nack  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o   = q.ctrl;
    assign sda_oe_o = q.oe;
    assign state_o  = q.state;

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int STRAP_W     = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [DATA_W-1:0]  status_i,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic               sda_oe_o
);

    logic [1:0]        line_s;
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [ADDR_W-1:0] own_addr;
    tgt_state_e        fsm_state;

    assign own_addr = {ADDR_HI, strap_i};

    i2c_bus_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (line_s)
    );

    assign scl_lvl = line_s[1];
    assign sda_lvl = line_s[0];

    i2c_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_lvl),
        .sda_s     (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .own_addr  (own_addr),
        .status_i  (status_i),
        .ctrl_o    (ctrl_o),
        .sda_oe_o  (sda_oe_o),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input tgt_state_e        fsm_state,
    input logic [DATA_W-1:0] ctrl_o,
    input logic              sda_oe_o
);

    assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == '0 && !sda_oe_o));

    assert_master_bit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && (fsm_state == ST_ADDR || fsm_state == ST_WR)) |-> !sda_oe_o);

    assert_start_to_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (fsm_state == ST_ADDR && !sda_oe_o));

    assert_stop_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (fsm_state == ST_IDLE && !sda_oe_o));

    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsm_state == ST_WR && scl_fall) |=> $stable(ctrl_o));

    assert_drive_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall));

    assert_release_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RD_ACK || fsm_state == ST_IDLE) |-> !sda_oe_o);

endmodule

bind strap_i2c_target i2c_tgt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .fsm_state (fsm_state),
    .ctrl_o    (ctrl_o),
    .sda_oe_o  (sda_oe_o)
);

// File: tb/test_strap_i2c_target.sv
`timescale 1ns/1ps
module test_strap_i2c_target;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [7:0] status = 8'h00;
    logic [7:0] ctrl;
    logic       sda_oe;
    logic       sda_bus;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    bit         ctrl_chk_en = 1'b0;
    bit         quiet_chk = 1'b0;
    logic [7:0] exp_ctrl = 8'h00;
    logic [7:0] wr_q[$];
    logic [7:0] rd_q[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    strap_i2c_target i_strap_i2c_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .status_i (status),
        .ctrl_o   (ctrl),
        .sda_oe_o (sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ctrl_chk_en) check(ctrl == exp_ctrl, "R9", ctrl, exp_ctrl);
            if (quiet_chk)   check(!sda_oe, "R8", sda_oe, 0);
        end
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; qw();
        scl_m = 1'b1; quiet_chk = 1'b1; qw(); qw();
        quiet_chk = 1'b0; scl_m = 1'b0; qw();
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack_bit);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack_bit);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        bit b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            v = {v[6:0], b};
        end
    endtask

    task automatic write_txn(input logic [7:0] addr, input bit matched);
        bit a;
        bus_start();
        send_byte(addr, a);
        check(a == !matched, matched ? "R1" : "R2", a, !matched);
        foreach (wr_q[k]) begin
            if (matched) ctrl_chk_en = 1'b0;
            send_byte(wr_q[k], a);
            check(a == !matched, matched ? "R3" : "R2", a, !matched);
            if (matched) begin
                exp_ctrl    = wr_q[k];
                ctrl_chk_en = 1'b1;
            end
        end
        bus_stop();
        check(ctrl == exp_ctrl, matched ? "R3" : "R2", ctrl, exp_ctrl);
    endtask

    task automatic read_txn(input logic [7:0] addr, input bit matched);
        bit a;
        logic [7:0] v;
        status = rd_q[0];
        bus_start();
        send_byte(addr, a);
        check(a == !matched, matched ? "R1" : "R2", a, !matched);
        if (matched) begin
            foreach (rd_q[k]) begin
                recv_byte(v);
                check(v == rd_q[k], "R4", v, rd_q[k]);
                if (k < rd_q.size() - 1) begin
                    status = rd_q[k+1];
                    send_bit(1'b0);
                end else begin
                    status = ~rd_q[k];
                    send_bit(1'b1);
                end
            end
            qw();
            check(!sda_oe, "R5", sda_oe, 0);
            recv_byte(v);
            check(v == 8'hFF, "R5", v, 8'hFF);
        end else begin
            recv_byte(v);
            check(v == 8'hFF, "R2", v, 8'hFF);
            send_bit(1'b1);
        end
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        check(ctrl == 8'h00, "R6", ctrl, 0);
        check(!sda_oe, "R6", sda_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ctrl == 8'h00, "R6", ctrl, 0);
        ctrl_chk_en = 1'b1;
        qw();

        // R1/R3: every strap value answers at 40h + 2*strap
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            qw();
            wr_q = '{8'h3C ^ 8'(s * 17)};
            write_txn(8'h40 + 8'(2 * s), 1'b1);
        end

        // R2: neighbouring address ignored
        strap = 3'd5;
        qw();
        wr_q = '{8'hFF, 8'h00};
        write_txn(8'h48, 1'b0);
        wr_q = '{8'h77};
        write_txn(8'h4C, 1'b0);

        // R3: several bytes, last one remains
        wr_q = '{8'h11, 8'h22, 8'h9D};
        write_txn(8'h4A, 1'b1);

        // R4/R5: multi-byte read with fresh status per byte
        rd_q = '{8'hC3, 8'h5A, 8'h0F};
        read_txn(8'h4B, 1'b1);
        rd_q = '{8'h80};
        read_txn(8'h4B, 1'b1);

        // R2: read at wrong address
        rd_q = '{8'h00};
        read_txn(8'h4F, 1'b0);

        // R7: stop in the middle of a data byte
        bus_start();
        send_byte(8'h4A, a);
        check(a == 1'b0, "R7", a, 0);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        check(ctrl == exp_ctrl, "R7", ctrl, exp_ctrl);

        // R7: repeated start after a write address becomes a read
        status = 8'h96;
        bus_start();
        send_byte(8'h4A, a);
        check(a == 1'b0, "R7", a, 0);
        bus_start();
        send_byte(8'h4B, a);
        check(a == 1'b0, "R7", a, 0);
        recv_byte(v);
        check(v == 8'h96, "R4", v, 8'h96);
        send_bit(1'b1);
        bus_stop();
        check(ctrl == exp_ctrl, "R7", ctrl, exp_ctrl);

        // R3: target still works after aborts
        wr_q = '{8'hE4};
        write_txn(8'h4A, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule